// File: doc/BRIEF.md
# Row-Column Bit Interleaver

This block reorders a frame of G coded bits before they are scrambled. The frame is treated as a matrix with Ncol columns and G/Ncol rows. Bits enter serially and fill the matrix one row at a time. They leave serially, one column at a time, top to bottom. Ncol is six times the slot count of the allocation, and the slot count is chosen with a two-bit code. The row count follows from G.

The matrix sits in a single-port RAM whose words each hold twelve bits of one row. An input packer gathers twelve bits before each write. On read-out every output bit costs one RAM read, and one bit of the fetched word is selected. A three-state controller steps through idle, write and read.

A frame begins with a one-cycle `start` pulse in idle, which latches the slot code and G. Both streams are valid/ready. An input bit is taken in any cycle where `in_valid` and `in_ready` are both high. An output bit is taken in any cycle where `out_valid` and `out_ready` are both high. Once `out_valid` is high, it stays high and `out_bit` holds its value until the bit is taken. The source may insert gaps at any point. The sink may hold `out_ready` low for any number of cycles.

Top module: `ilv_top`

## Requirements
- R1: After a synchronous active-high reset, the block is idle: `in_ready`, `out_valid` and `done` are all low.
- R2: A `start` pulse in idle latches `cfg_slots` and `cfg_g`, and `in_ready` is high in the following cycle. A `start` pulse, or a change of the configuration inputs, outside idle has no effect on the frame in progress.
- R3: In the write phase the block accepts exactly G bits. After the last of them, `in_ready` stays low until a new frame is started.
- R4: Input bit number n = r·Ncol + c (counted from 0 in arrival order) is emitted as output bit number c·Nrow + r, where Nrow = G/Ncol. The row index advances fastest.
- R5: The column count depends on `cfg_slots`: code 0 gives Ncol = 12, code 1 gives 24, code 2 gives 48 and code 3 gives 96.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high in the next cycle and `out_bit` is unchanged.
- R7: Exactly G output bits are emitted per frame. `done` is high for exactly one cycle, the cycle after the last output handshake. In that cycle `out_valid` and `in_ready` are low and the block is idle again.
- R8: When the sink holds `out_ready` high, `out_valid` has no gap from the first output bit to the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame (sampled in idle only) |
| cfg_slots | input | 2 | Slot code: 0/1/2/3 give 2/4/8/16 slots |
| cfg_g | input | 12 | Frame length G in bits |
| in_valid | input | 1 | Input bit valid |
| in_ready | output | 1 | Block can take an input bit |
| in_bit | input | 1 | Input bit |
| out_valid | output | 1 | Output bit valid |
| out_ready | input | 1 | Sink can take an output bit |
| out_bit | output | 1 | Output bit |
| done | output | 1 | One-cycle pulse after the last output bit |

## Verification
The address assertions assume that G is nonzero, is at most 2880, and is a whole multiple of the chosen Ncol, so that every row spans a whole number of RAM words. The stimulus only uses G values that are multiples of Ncol for each slot code, including the one-row case and the 2880-bit maximum. The hold assertion assumes the sink never takes a bit that is not valid. The bench drives `out_ready` freely and counts a transfer only when both handshake signals are high. The stray `start` is sent only while the read phase is running, with a different slot code, and the bench then checks that the output order is still the one the original configuration gives.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned ILV_W     = 12;
  localparam int unsigned ILV_MAX_G = 2880;
  localparam int unsigned ILV_SW    = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } ilv_state_e;
endpackage

// File: rtl/ilv_pack.sv
module ilv_pack #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         take,
  input  logic         bit_in,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  localparam int unsigned IW = $clog2(W);

  logic [IW-1:0] idx_q;
  logic [W-1:0]  acc_q;

  assign full_o = (idx_q == IW'(W - 1));

  for (genvar k = 0; k < W; k++) begin : g_lane
    assign word_o[k] = (idx_q == IW'(k)) ? bit_in : acc_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      idx_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      acc_q <= word_o;
      idx_q <= full_o ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/ilv_ram.sv
module ilv_ram #(
  parameter int unsigned DW    = 12,
  parameter int unsigned DEPTH = 240,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned W     = 12,
  parameter int unsigned MAX_G = 2880,
  parameter int unsigned SW    = 2,
  localparam int unsigned DEPTH = MAX_G / W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned GW    = $clog2(MAX_G + 1),
  localparam int unsigned CBW   = $clog2(W),
  localparam int unsigned MAXSH = (1 << SW) - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] cfg_slots,
  input  logic [GW-1:0] cfg_g,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          pack_full,
  output logic          pack_clr,
  output logic          pack_take,
  output logic          ram_we,
  output logic          ram_re,
  output logic [AW-1:0] ram_addr,
  input  logic [W-1:0]  ram_q,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          done
);
  ilv_state_e state_q;

  logic [SW-1:0]  sel_q;
  logic [GW-1:0]  g_q;
  logic [AW-1:0]  words_q;
  logic [AW-1:0]  nrow_q;
  logic [AW-1:0]  wr_addr_q;
  logic [AW-1:0]  rd_row_q;
  logic [AW-1:0]  rd_cw_q;
  logic [CBW-1:0] rd_cb_q;
  logic [GW-1:0]  rd_cnt_q;
  logic           rd_all_q;
  logic [CBW-1:0] bsel_q;
  logic           olast_q;
  logic           oval_q;
  logic           done_q;

  logic [AW+MAXSH-1:0] rd_addr_w;
  logic [AW-1:0]       rd_addr;
  logic                accept;
  logic                out_hs;
  logic                last_issue;
  logic                row_wrap;

  assign in_ready   = (state_q == ST_WRITE);
  assign accept     = in_valid && in_ready;
  assign pack_take  = accept;
  assign pack_clr   = (state_q == ST_IDLE);
  assign ram_we     = accept && pack_full;
  assign ram_re     = (state_q == ST_READ) && !rd_all_q && (!oval_q || out_ready);
  assign out_hs     = oval_q && out_ready;
  assign last_issue = (rd_cnt_q == g_q - 1'b1);
  assign row_wrap   = (rd_row_q == nrow_q - 1'b1);

  assign rd_addr_w = ({{MAXSH{1'b0}}, rd_row_q} << sel_q) + (AW+MAXSH)'(rd_cw_q);
  assign rd_addr   = rd_addr_w[AW-1:0];
  assign ram_addr  = (state_q == ST_WRITE) ? wr_addr_q : rd_addr;

  assign out_valid = oval_q;
  assign out_bit   = ram_q[bsel_q];
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_q     <= '0;
      g_q       <= '0;
      words_q   <= '0;
      nrow_q    <= '0;
      wr_addr_q <= '0;
      rd_row_q  <= '0;
      rd_cw_q   <= '0;
      rd_cb_q   <= '0;
      rd_cnt_q  <= '0;
      rd_all_q  <= 1'b0;
      bsel_q    <= '0;
      olast_q   <= 1'b0;
      oval_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            sel_q     <= cfg_slots;
            g_q       <= cfg_g;
            words_q   <= AW'(cfg_g / GW'(W));
            nrow_q    <= AW'(cfg_g / GW'(W)) >> cfg_slots;
            wr_addr_q <= '0;
            state_q   <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (ram_we) begin
            wr_addr_q <= wr_addr_q + 1'b1;
            if (wr_addr_q == words_q - 1'b1) begin
              state_q  <= ST_READ;
              rd_row_q <= '0;
              rd_cw_q  <= '0;
              rd_cb_q  <= '0;
              rd_cnt_q <= '0;
              rd_all_q <= 1'b0;
            end
          end
        end
        ST_READ: begin
          if (ram_re) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
            bsel_q   <= rd_cb_q;
            olast_q  <= last_issue;
            oval_q   <= 1'b1;
            if (last_issue) rd_all_q <= 1'b1;
            if (row_wrap) begin
              rd_row_q <= '0;
              if (rd_cb_q == CBW'(W - 1)) begin
                rd_cb_q <= '0;
                rd_cw_q <= rd_cw_q + 1'b1;
              end else begin
                rd_cb_q <= rd_cb_q + 1'b1;
              end
            end else begin
              rd_row_q <= rd_row_q + 1'b1;
            end
          end else if (out_ready) begin
            oval_q <= 1'b0;
          end
          if (out_hs && olast_q) begin
            done_q  <= 1'b1;
            oval_q  <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ram_re |-> (ram_addr < words_q)); // R4

  AST_WADDR_BOUND: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (wr_addr_q < words_q)); // R3

  AST_START_OPENS_INPUT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start) |=> in_ready); // R2
endmodule

// File: rtl/ilv_top.sv
module ilv_top
  import ilv_pkg::*;
#(
  parameter int unsigned W     = ILV_W,
  parameter int unsigned MAX_G = ILV_MAX_G,
  parameter int unsigned SW    = ILV_SW,
  localparam int unsigned DEPTH = MAX_G / W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned GW    = $clog2(MAX_G + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [SW-1:0] cfg_slots,
  input  logic [GW-1:0] cfg_g,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_bit,
  output logic          done
);
  logic          pack_full;
  logic          pack_clr;
  logic          pack_take;
  logic [W-1:0]  pack_word;
  logic          ram_we;
  logic          ram_re;
  logic [AW-1:0] ram_addr;
  logic [W-1:0]  ram_q;

  ilv_pack #(.W(W)) u_pack (
    .clk    (clk),
    .rst    (rst),
    .clr    (pack_clr),
    .take   (pack_take),
    .bit_in (in_bit),
    .word_o (pack_word),
    .full_o (pack_full)
  );

  ilv_ram #(.DW(W), .DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .re    (ram_re),
    .addr  (ram_addr),
    .wdata (pack_word),
    .rdata (ram_q)
  );

  ilv_ctrl #(.W(W), .MAX_G(MAX_G), .SW(SW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .cfg_slots (cfg_slots),
    .cfg_g     (cfg_g),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pack_full (pack_full),
    .pack_clr  (pack_clr),
    .pack_take (pack_take),
    .ram_we    (ram_we),
    .ram_re    (ram_re),
    .ram_addr  (ram_addr),
    .ram_q     (ram_q),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .done      (done)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !in_ready)); // R7
endmodule

// File: tb/ilv_top_bench.sv
module ilv_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  cfg_slots = '0;
  logic [11:0] cfg_g = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_bit = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_bit;
  logic        done;

  int tests = 0;
  int fails = 0;
  int unsigned rs = 32'h1234_5678;
  bit frame [2880];

  always #2 clk = ~clk;

  ilv_top u_ilv_top (
    .clk(clk), .rst(rst), .start(start), .cfg_slots(cfg_slots), .cfg_g(cfg_g),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit), .done(done)
  );

  function automatic bit rnd_bit();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs[7];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int sel, input int g, input bit rnd, input bit stray);
    int ncol, nrow, idx, oidx, cyc, gaps, bad_r3, bad_bits;
    bit fin, started, hold_pend, hold_bit, stray_done;
    ncol = 6 * (2 << sel);
    nrow = g / ncol;
    idx = 0; oidx = 0; cyc = 0; gaps = 0; bad_r3 = 0; bad_bits = 0;
    fin = 0; started = 0; hold_pend = 0; hold_bit = 0; stray_done = 0;
    for (int i = 0; i < g; i++) frame[i] = rnd_bit();
    @(negedge clk);
    cfg_slots = 2'(sel); cfg_g = 12'(g); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(in_ready == 1'b1, "R2 in_ready after start", int'(in_ready), 1);
    while (!fin && cyc < 30000) begin
      start = 1'b0;
      if (hold_pend) begin
        check(out_valid && out_bit == hold_bit, "R6 hold", int'(out_bit), int'(hold_bit));
        hold_pend = 0;
      end
      if (done) begin
        check(oidx == g, "R7 output count", oidx, g);
        check(!out_valid && !in_ready, "R7 quiet at done", int'(out_valid), 0);
        fin = 1;
      end else begin
        if (idx == g && in_ready) bad_r3++;
        in_valid = (idx < g) && (rnd ? rnd_bit() : 1'b1);
        in_bit = (idx < g) ? frame[idx] : 1'b0;
        if (in_valid && in_ready) idx++;
        out_ready = rnd ? rnd_bit() : 1'b1;
        if (out_valid) begin
          started = 1;
          if (out_ready) begin
            int c, r;
            c = oidx / nrow;
            r = oidx % nrow;
            if (out_bit != frame[r * ncol + c]) begin
              bad_bits++;
              check(0, "R4/R5 order", int'(out_bit), int'(frame[r * ncol + c]));
            end
            oidx++;
          end else begin
            hold_pend = 1;
            hold_bit = out_bit;
          end
        end else if (started) begin
          gaps++;
        end
        if (stray && !stray_done && oidx == 2) begin
          start = 1'b1;
          cfg_slots = 2'(sel ^ 1);
          cfg_g = 12'(ncol);
          stray_done = 1;
        end
      end
      @(negedge clk);
      cyc++;
    end
    in_valid = 1'b0; out_ready = 1'b0; start = 1'b0;
    check(fin, "R7 done seen", int'(fin), 1);
    check(bad_bits == 0, "R4 frame order", bad_bits, 0);
    check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    check(bad_r3 == 0, "R3 no input after G", bad_r3, 0);
    check(idx == g, "R3 accepted count", idx, g);
    if (!rnd) check(gaps == 0, "R8 no output gap", gaps, 0);
    if (stray) check(!in_ready, "R2 stray start ignored", int'(in_ready), 0);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !done, "R1 reset state", int'(in_ready | out_valid | done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!in_ready && !out_valid && !done, "R1 idle after reset", int'(in_ready | out_valid | done), 0);
    run_case(0, 12, 0, 0);
    run_case(0, 144, 1, 0);
    run_case(1, 48, 1, 0);
    run_case(1, 240, 0, 0);
    run_case(2, 96, 1, 1);
    run_case(2, 480, 1, 0);
    run_case(3, 96, 1, 0);
    run_case(3, 2880, 1, 0);
    run_case(0, 2880, 0, 0);
    run_case(3, 960, 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule